// File: doc/BRIEF.md
# Paged Address Translation Map

This block translates the 24-bit addresses issued by a network controller into physical addresses for a small on-board packet RAM. It does this through a writable table of 16-bit page entries. The low ten address bits are the byte offset within a 1 KiB page. The next ten bits pick one of 1024 slots. The top four bits take no part in the translation.

Each slot holds three things: a physical frame number, a flag that gives the byte order used for the page, and a select that says whether the page lives in on-board RAM or on the expansion bus. The host loads slots and reads them back over a 16-bit register port. Two lookup ports share the same table. One serves the controller and the other serves host accesses to the RAM window. Each lookup port returns a registered physical address, the byte-order and memory-select bits, and an out-of-range flag. Several slots may name the same frame. This lets the last slot alias a low frame, so that the controller's fixed boot structure near the top of its address space lands in real RAM.

Top module: `page_xlate_map`

## Requirements
- R1: After reset, every slot reads back as 0x0000, and valid_o and oob_o are low on both lookup ports.
- R2: A host write stores the whole 16-bit word in the slot given by map_slot_i. The read port map_rdata_o shows the contents of the slot selected by map_slot_i, combinationally, from the edge that follows the write.
- R3: Address bits 23:20 have no effect on the translation.
- R4: For a request, address bits 19:10 select the slot and bits 9:0 are the offset. One clock after valid_i, addr_o equals {frame, offset}, where frame is bits 11:0 of the entry.
- R5: bigend_o is entry bit 15, registered together with the address. 1 means host (big-endian) byte order and 0 means little-endian.
- R6: xbus_o is entry bit 13 (1 = expansion-bus memory). An expansion-bus access is valid for any frame number.
- R7: An on-board access (bit 13 = 0) whose frame is 256 or more sets oob_o and keeps valid_o low. A valid on-board result always has a frame below 256.
- R8: The controller and host ports translate through the same table, independently and in the same cycle.
- R9: If slot 1023 is loaded with frame 0, address 0xFFFFF4 translates to physical address 0x3F4.
- R10: A lookup in the same cycle as a host write to its slot uses the old entry. The next lookup uses the new entry.
- R11: One clock after valid_i is low, valid_o and oob_o are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| map_wr_i | input | 1 | Host write strobe for a table slot |
| map_slot_i | input | 10 | Slot index for host write and read-back |
| map_wdata_i | input | 16 | Entry value to write |
| map_rdata_o | output | 16 | Current contents of the selected slot |
| ctl_valid_i | input | 1 | Controller lookup request |
| ctl_addr_i | input | 24 | Controller address |
| ctl_valid_o | output | 1 | Controller result addresses real memory |
| ctl_oob_o | output | 1 | Controller on-board frame out of range |
| ctl_bigend_o | output | 1 | Controller page byte order |
| ctl_xbus_o | output | 1 | Controller page on expansion bus |
| ctl_addr_o | output | 22 | Controller physical address |
| hst_valid_i | input | 1 | Host window lookup request |
| hst_addr_i | input | 24 | Host window address |
| hst_valid_o | output | 1 | Host result addresses real memory |
| hst_oob_o | output | 1 | Host on-board frame out of range |
| hst_bigend_o | output | 1 | Host page byte order |
| hst_xbus_o | output | 1 | Host page on expansion bus |
| hst_addr_o | output | 22 | Host physical address |

## Verification
The hardest case to reach from the ports is the collision between a host write and a lookup of the same slot in the same cycle. There the result must come from the old entry, and the new entry must appear only on the following lookup. The bench forces this by raising map_wr_i on slot 0 during the very cycle in which it presents a controller address inside that slot. It then repeats the lookup one cycle later and expects the new frame. The alias at the top of the address space is reached by loading slot 1023 with frame 0 and requesting 0xFFFFF4. The range boundary is covered with on-board frames 255 and 256 and with an expansion-bus frame above 255.

// File: rtl/pxm_pkg.sv
package pxm_pkg;
  localparam int ENTRY_W = 16;
  localparam int FRAME_W = 12;

  // bit positions are decoded by the lookup stage
  typedef struct packed {
    logic               bigend;    // 15
    logic               rsv_14;
    logic               xbus;      // 13
    logic               rsv_12;
    logic [FRAME_W-1:0] frame;     // 11:0
  } pxm_entry_t;
endpackage

// File: rtl/pxm_table.sv
module pxm_table
  import pxm_pkg::*;
#(
  parameter int SLOT_W = 10,
  parameter int NUM_RD = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  pxm_entry_t        wr_data_i,
  input  logic [SLOT_W-1:0] rd_slot_i [NUM_RD],
  output pxm_entry_t        rd_data_o [NUM_RD]
);
  localparam int SLOTS = 1 << SLOT_W;

  pxm_entry_t mem_q [SLOTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SLOTS; i++) mem_q[i] <= '0;
    end else if (wr_i) begin
      mem_q[wr_slot_i] <= wr_data_i;
    end
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
    assign rd_data_o[g] = mem_q[rd_slot_i[g]];
  end
endmodule

// File: rtl/pxm_lookup.sv
module pxm_lookup
  import pxm_pkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int SLOT_W        = 10,
  parameter int OFFS_W        = 10,
  parameter int ONBOARD_PAGES = 256,
  localparam int PHYS_W       = FRAME_W + OFFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [SLOT_W-1:0] slot_o,
  input  pxm_entry_t        entry_i,
  output logic              valid_o,
  output logic              oob_o,
  output logic              bigend_o,
  output logic              xbus_o,
  output logic [PHYS_W-1:0] phys_o
);
  localparam int HI_LSB = SLOT_W + OFFS_W;
  localparam logic [FRAME_W-1:0] FRAME_LIMIT = FRAME_W'(ONBOARD_PAGES);

  logic oob_c;
  logic unused_bits;

  // upper address bits and reserved entry bits take no part
  assign unused_bits = ^{addr_i[ADDR_W-1:HI_LSB], entry_i.rsv_14, entry_i.rsv_12};

  assign slot_o = addr_i[OFFS_W +: SLOT_W];
  assign oob_c  = !entry_i.xbus && (entry_i.frame >= FRAME_LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      oob_o    <= 1'b0;
      bigend_o <= 1'b0;
      xbus_o   <= 1'b0;
      phys_o   <= '0;
    end else begin
      valid_o  <= valid_i && !oob_c;
      oob_o    <= valid_i && oob_c;
      bigend_o <= entry_i.bigend;
      xbus_o   <= entry_i.xbus;
      phys_o   <= {entry_i.frame, addr_i[OFFS_W-1:0]};
    end
  end
endmodule

// File: rtl/page_xlate_map.sv
module page_xlate_map
  import pxm_pkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int SLOT_W        = 10,
  parameter int OFFS_W        = 10,
  parameter int ONBOARD_PAGES = 256,
  localparam int PHYS_W       = FRAME_W + OFFS_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               map_wr_i,
  input  logic [SLOT_W-1:0]  map_slot_i,
  input  logic [ENTRY_W-1:0] map_wdata_i,
  output logic [ENTRY_W-1:0] map_rdata_o,
  input  logic               ctl_valid_i,
  input  logic [ADDR_W-1:0]  ctl_addr_i,
  output logic               ctl_valid_o,
  output logic               ctl_oob_o,
  output logic               ctl_bigend_o,
  output logic               ctl_xbus_o,
  output logic [PHYS_W-1:0]  ctl_addr_o,
  input  logic               hst_valid_i,
  input  logic [ADDR_W-1:0]  hst_addr_i,
  output logic               hst_valid_o,
  output logic               hst_oob_o,
  output logic               hst_bigend_o,
  output logic               hst_xbus_o,
  output logic [PHYS_W-1:0]  hst_addr_o
);
  localparam int NUM_LK = 2;           // 0: controller, 1: host window
  localparam int NUM_RD = NUM_LK + 1;  // last read port: host read-back
  localparam int RB     = NUM_LK;

  logic [SLOT_W-1:0] rd_slot [NUM_RD];
  pxm_entry_t        rd_ent  [NUM_RD];

  logic              lk_vin  [NUM_LK];
  logic [ADDR_W-1:0] lk_addr [NUM_LK];
  logic              lk_vout [NUM_LK];
  logic              lk_oob  [NUM_LK];
  logic              lk_be   [NUM_LK];
  logic              lk_xb   [NUM_LK];
  logic [PHYS_W-1:0] lk_phys [NUM_LK];

  assign lk_vin[0]  = ctl_valid_i;
  assign lk_addr[0] = ctl_addr_i;
  assign lk_vin[1]  = hst_valid_i;
  assign lk_addr[1] = hst_addr_i;

  pxm_table #(
    .SLOT_W (SLOT_W),
    .NUM_RD (NUM_RD)
  ) table_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (map_wr_i),
    .wr_slot_i (map_slot_i),
    .wr_data_i (pxm_entry_t'(map_wdata_i)),
    .rd_slot_i (rd_slot),
    .rd_data_o (rd_ent)
  );

  assign rd_slot[RB] = map_slot_i;
  assign map_rdata_o = rd_ent[RB];

  for (genvar p = 0; p < NUM_LK; p++) begin : g_lk
    pxm_lookup #(
      .ADDR_W        (ADDR_W),
      .SLOT_W        (SLOT_W),
      .OFFS_W        (OFFS_W),
      .ONBOARD_PAGES (ONBOARD_PAGES)
    ) lookup_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (lk_vin[p]),
      .addr_i   (lk_addr[p]),
      .slot_o   (rd_slot[p]),
      .entry_i  (rd_ent[p]),
      .valid_o  (lk_vout[p]),
      .oob_o    (lk_oob[p]),
      .bigend_o (lk_be[p]),
      .xbus_o   (lk_xb[p]),
      .phys_o   (lk_phys[p])
    );
  end

  assign ctl_valid_o  = lk_vout[0];
  assign ctl_oob_o    = lk_oob[0];
  assign ctl_bigend_o = lk_be[0];
  assign ctl_xbus_o   = lk_xb[0];
  assign ctl_addr_o   = lk_phys[0];
  assign hst_valid_o  = lk_vout[1];
  assign hst_oob_o    = lk_oob[1];
  assign hst_bigend_o = lk_be[1];
  assign hst_xbus_o   = lk_xb[1];
  assign hst_addr_o   = lk_phys[1];
endmodule

// File: rtl/pxm_checker.sv
module pxm_checker
  import pxm_pkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int SLOT_W        = 10,
  parameter int OFFS_W        = 10,
  parameter int ONBOARD_PAGES = 256,
  localparam int PHYS_W       = FRAME_W + OFFS_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               map_wr_i,
  input logic [SLOT_W-1:0]  map_slot_i,
  input logic [ENTRY_W-1:0] map_wdata_i,
  input logic [ENTRY_W-1:0] map_rdata_o,
  input logic               ctl_valid_i,
  input logic [ADDR_W-1:0]  ctl_addr_i,
  input logic               ctl_valid_o,
  input logic               ctl_oob_o,
  input logic               ctl_bigend_o,
  input logic               ctl_xbus_o,
  input logic [PHYS_W-1:0]  ctl_addr_o,
  input logic               hst_valid_i,
  input logic [ADDR_W-1:0]  hst_addr_i,
  input logic               hst_valid_o,
  input logic               hst_oob_o,
  input logic               hst_bigend_o,
  input logic               hst_xbus_o,
  input logic [PHYS_W-1:0]  hst_addr_o
);
  localparam logic [FRAME_W-1:0] FRAME_LIMIT = FRAME_W'(ONBOARD_PAGES);

  assert_readback_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(map_wr_i) && $past(rst_ni) && $stable(map_slot_i)) |-> map_rdata_o == $past(map_wdata_i));

  assert_offset_ctl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_valid_o |-> ctl_addr_o[OFFS_W-1:0] == $past(ctl_addr_i[OFFS_W-1:0]));

  assert_offset_hst_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hst_valid_o |-> hst_addr_o[OFFS_W-1:0] == $past(hst_addr_i[OFFS_W-1:0]));

  assert_oob_ctl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_oob_o |-> (!ctl_valid_o && !ctl_xbus_o));

  assert_oob_hst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hst_oob_o |-> (!hst_valid_o && !hst_xbus_o));

  assert_onboard_ctl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_valid_o && !ctl_xbus_o) |-> ctl_addr_o[PHYS_W-1:OFFS_W] < FRAME_LIMIT);

  assert_onboard_hst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hst_valid_o && !hst_xbus_o) |-> hst_addr_o[PHYS_W-1:OFFS_W] < FRAME_LIMIT);

  assert_idle_ctl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ctl_valid_i) |-> (!ctl_valid_o && !ctl_oob_o));

  assert_idle_hst_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(hst_valid_i) |-> (!hst_valid_o && !hst_oob_o));
endmodule

bind page_xlate_map pxm_checker #(
  .ADDR_W        (ADDR_W),
  .SLOT_W        (SLOT_W),
  .OFFS_W        (OFFS_W),
  .ONBOARD_PAGES (ONBOARD_PAGES)
) chk_i (.*);

// File: tb/page_xlate_map_tb_top.sv
`timescale 1ns/1ps
module page_xlate_map_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        map_wr_i;
  logic [9:0]  map_slot_i;
  logic [15:0] map_wdata_i;
  logic [15:0] map_rdata_o;
  logic        ctl_valid_i, hst_valid_i;
  logic [23:0] ctl_addr_i, hst_addr_i;
  logic        ctl_valid_o, ctl_oob_o, ctl_bigend_o, ctl_xbus_o;
  logic        hst_valid_o, hst_oob_o, hst_bigend_o, hst_xbus_o;
  logic [21:0] ctl_addr_o, hst_addr_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk_i = ~clk_i;

  page_xlate_map dut_i (.*);

  // {addr[49:26], valid, oob, bigend, xbus, phys[21:0]}
  localparam logic [49:0] VEC [9] = '{
    {24'h000010, 1'b1, 1'b0, 1'b1, 1'b0, 22'h001410},  // R4 R5 slot 0
    {24'hF00010, 1'b1, 1'b0, 1'b1, 1'b0, 22'h001410},  // R3 top bits ignored
    {24'h0007FF, 1'b1, 1'b0, 1'b0, 1'b0, 22'h0003FF},  // R5 little-endian
    {24'h000BAB, 1'b1, 1'b0, 1'b0, 1'b1, 22'h048FAB},  // R6 xbus frame 0x123
    {24'h000C00, 1'b0, 1'b1, 1'b0, 1'b0, 22'h000000},  // R7 frame 256
    {24'hFFFFF4, 1'b1, 1'b0, 1'b1, 1'b0, 22'h0003F4},  // R9 alias
    {24'h580001, 1'b1, 1'b0, 1'b1, 1'b1, 22'h03FC01},  // R3 R4 slot 512
    {24'h0013FF, 1'b1, 1'b0, 1'b0, 1'b0, 22'h03FFFF},  // R7 frame 255 ok
    {24'h7FF000, 1'b1, 1'b0, 1'b0, 1'b0, 22'h000000}   // R1 unwritten slot
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic map_write(logic [9:0] slot, logic [15:0] data);
    @(negedge clk_i);
    map_wr_i = 1'b1; map_slot_i = slot; map_wdata_i = data;
    @(negedge clk_i);
    map_wr_i = 1'b0;
  endtask

  task automatic map_read_chk(string req, logic [9:0] slot, logic [15:0] exp);
    @(negedge clk_i);
    map_slot_i = slot;
    #1;
    chk(req, 32'(map_rdata_o), 32'(exp));
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; map_wr_i = 1'b0; map_slot_i = '0; map_wdata_i = '0;
    ctl_valid_i = 1'b0; ctl_addr_i = '0; hst_valid_i = 1'b0; hst_addr_i = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R1 reset state
    chk("R1 ctl flags", {30'd0, ctl_valid_o, ctl_oob_o}, 32'd0);
    chk("R1 hst flags", {30'd0, hst_valid_o, hst_oob_o}, 32'd0);
    map_read_chk("R1 slot0", 10'd0, 16'h0000);
    map_read_chk("R1 slot1023", 10'd1023, 16'h0000);

    map_write(10'd0,    16'h8005);
    map_write(10'd1,    16'h0000);
    map_write(10'd2,    16'h2123);
    map_write(10'd3,    16'h0100);
    map_write(10'd4,    16'h00FF);
    map_write(10'd512,  16'hA0FF);
    map_write(10'd1023, 16'h8000);

    // R2 read-back
    map_read_chk("R2 slot2", 10'd2, 16'h2123);
    map_read_chk("R2 slot512", 10'd512, 16'hA0FF);
    map_read_chk("R2 slot1023", 10'd1023, 16'h8000);

    // vector table on both ports (R8 shared table)
    for (int i = 0; i < 9; i++) begin
      @(negedge clk_i);
      ctl_valid_i = 1'b1; ctl_addr_i = VEC[i][49:26];
      hst_valid_i = 1'b1; hst_addr_i = VEC[i][49:26];
      @(posedge clk_i); #1;
      if (VEC[i][25]) begin
        chk($sformatf("R3/R4/R5/R6/R9 ctl vec %0d", i),
            {6'd0, ctl_valid_o, ctl_oob_o, ctl_bigend_o, ctl_xbus_o, ctl_addr_o},
            {6'd0, VEC[i][25:0]});
        chk($sformatf("R8 hst vec %0d", i),
            {6'd0, hst_valid_o, hst_oob_o, hst_bigend_o, hst_xbus_o, hst_addr_o},
            {6'd0, VEC[i][25:0]});
      end else begin
        chk($sformatf("R7 ctl vec %0d", i), {30'd0, ctl_valid_o, ctl_oob_o},
            {30'd0, VEC[i][25:24]});
        chk($sformatf("R7 hst vec %0d", i), {30'd0, hst_valid_o, hst_oob_o},
            {30'd0, VEC[i][25:24]});
      end
    end

    // R11 idle request clears outputs
    @(negedge clk_i);
    ctl_valid_i = 1'b0; hst_valid_i = 1'b0;
    @(posedge clk_i); #1;
    chk("R11 ctl idle", {30'd0, ctl_valid_o, ctl_oob_o}, 32'd0);
    chk("R11 hst idle", {30'd0, hst_valid_o, hst_oob_o}, 32'd0);

    // R8 independent lookups in one cycle
    @(negedge clk_i);
    ctl_valid_i = 1'b1; ctl_addr_i = 24'h000010;
    hst_valid_i = 1'b1; hst_addr_i = 24'h000C00;
    @(posedge clk_i); #1;
    chk("R8 ctl", {9'd0, ctl_valid_o, ctl_addr_o}, {9'd0, 1'b1, 22'h001410});
    chk("R8 hst", {30'd0, hst_valid_o, hst_oob_o}, {30'd0, 2'b01});

    // R10 write collides with lookup of the same slot
    @(negedge clk_i);
    hst_valid_i = 1'b0;
    map_wr_i = 1'b1; map_slot_i = 10'd0; map_wdata_i = 16'h8007;
    @(posedge clk_i); #1;
    chk("R10 old entry", {9'd0, ctl_valid_o, ctl_addr_o}, {9'd0, 1'b1, 22'h001410});
    @(negedge clk_i);
    map_wr_i = 1'b0;
    @(posedge clk_i); #1;
    chk("R10 new entry", {9'd0, ctl_valid_o, ctl_addr_o}, {9'd0, 1'b1, 22'h001C10});
    @(negedge clk_i);
    ctl_valid_i = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule